// File: doc/BRIEF.md
# Stop-State Wake and Oscillator Settle Controller

This controller owns a processor's low-power stop state. When the core requests stop, the controller turns off the gated clock enable for the core and its peripherals. It then watches three wake sources: a warm reset, a maskable interrupt line and a non-maskable interrupt line. The core's mask bits are frozen while the core is stopped, so the controller can read them during this time. For each wake source it decides whether that source is allowed to end the stop. It also decides whether an oscillator settle interval must pass before the clocks are released. When the clocks come back, it tells the core what to do next: begin interrupt service, continue with the instruction after the stop, or run a reset sequence.

The controller is clocked by a free-running oscillator clock that keeps running while the gated clocks are off. A settle-enable bit selects whether the settle interval applies after an interrupt wake. Every reset sets this bit again. A power-on reset always runs the settle interval. A warm reset that arrives while the clocks are running does not run it.

Top module: `stop_wake_ctrl`

## Requirements
- R1: While `stopped` is 0 and `ext_rst` is 0, a high `stop_req` sampled at a clock edge makes `stopped`=1 and `clk_en`=0 from that edge on. Both hold until a wake is accepted.
- R2: While stopped, `irq_req` wakes the block only when `irq_mask`=0, and the release cycle then carries a one-cycle `svc_irq` pulse. When `irq_mask`=1, the request is ignored and the block stays stopped.
- R3: While stopped, `nmi_req` wakes the block for both values of `nmi_mask`.
- R4: A non-maskable wake with `nmi_mask`=0 gives a one-cycle `svc_nmi` pulse in the first cycle with `clk_en`=1.
- R5: A non-maskable wake with `nmi_mask`=1 gives a one-cycle `resume` pulse in the first cycle with `clk_en`=1. It gives no `svc_nmi` or `svc_irq` pulse.
- R6: With `settle_en`=1, an accepted interrupt wake keeps `clk_en` at 0 for `SETTLE_CYCLES` cycles after the sampling edge. `clk_en` rises at the next edge, together with a one-cycle `settle_done` pulse. With `settle_en`=0, `clk_en` rises at the sampling edge itself.
- R7: Every reset sets `settle_en` to 1. While running and not in reset, `settle_we`=1 loads `settle_wd` into `settle_en`.
- R8: A reset sampled while stopped always runs the settle interval, even when `settle_en` was 0. `core_rst` stays 1 throughout that interval, and the release gives no `svc_irq`, `svc_nmi` or `resume` pulse.
- R9: After `por_n` is released, `clk_en` stays 0 and `core_rst` stays 1 for `SETTLE_CYCLES` edges, whatever value `settle_en` had before.
- R10: A warm reset sampled while running keeps `clk_en` at 1, with no settle interval. `core_rst` follows `ext_rst`.
- R11: When wake sources arrive together, reset wins over both interrupts, and the non-maskable interrupt wins over the maskable one.
- R12: Wake requests are sampled only in the stopped state. While running, `irq_req` and `nmi_req` produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst | input | 1 | Warm reset, synchronous, active high |
| stop_req | input | 1 | Core requests the stop state |
| irq_req | input | 1 | Maskable interrupt request, level |
| irq_mask | input | 1 | Core mask bit for the maskable interrupt |
| nmi_req | input | 1 | Non-maskable interrupt request, level |
| nmi_mask | input | 1 | Core mask bit for the non-maskable interrupt |
| settle_we | input | 1 | Write strobe for the settle-enable bit |
| settle_wd | input | 1 | Value to write to the settle-enable bit |
| clk_en | output | 1 | Gate enable for the core and peripheral clocks |
| stopped | output | 1 | Block is in the stop state |
| core_rst | output | 1 | Reset sequence to the core |
| settle_en | output | 1 | Current settle-enable bit |
| settle_done | output | 1 | Pulse when the settle interval expires |
| svc_irq | output | 1 | Pulse: start maskable interrupt service |
| svc_nmi | output | 1 | Pulse: start non-maskable interrupt service |
| resume | output | 1 | Pulse: continue after the stop instruction |

## Verification
A wrong wake decision is visible within one sampling cycle. Either `clk_en` stays low too long, or it rises while `stopped` should still hold. A wrong outcome code shows up in the release cycle as the wrong pulse, or as two pulses at once. A wrong settle counter changes the number of cycles from the wake edge to the rise of `clk_en`, and this is seen as soon as the interval ends. A wrong reset handling of the enable bit is visible on `settle_en` in the cycle after the reset.

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl #(
  parameter int SETTLE_CYCLES = 4064
) (
  input  logic clk,
  input  logic por_n,
  input  logic ext_rst,
  input  logic stop_req,
  input  logic irq_req,
  input  logic irq_mask,
  input  logic nmi_req,
  input  logic nmi_mask,
  input  logic settle_we,
  input  logic settle_wd,
  output logic clk_en,
  output logic stopped,
  output logic core_rst,
  output logic settle_en,
  output logic settle_done,
  output logic svc_irq,
  output logic svc_nmi,
  output logic resume
);

  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_SETTLE} st_t;
  typedef enum logic [1:0] {K_RST, K_NMI, K_IRQ, K_RES} kind_t;

  st_t          st;
  kind_t        kind;
  logic [CW-1:0] cnt;

  logic  wake;
  kind_t wk;

  assign wake = nmi_req | (irq_req & ~irq_mask);
  assign wk   = nmi_req ? (nmi_mask ? K_RES : K_NMI) : K_IRQ;

  assign clk_en   = (st == S_RUN);
  assign stopped  = (st == S_STOP);
  assign core_rst = ext_rst | (st == S_SETTLE && kind == K_RST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st          <= S_SETTLE;
      kind        <= K_RST;
      cnt         <= '0;
      settle_en   <= 1'b1;
      settle_done <= 1'b0;
      svc_irq     <= 1'b0;
      svc_nmi     <= 1'b0;
      resume      <= 1'b0;
    end else begin
      settle_done <= 1'b0;
      svc_irq     <= 1'b0;
      svc_nmi     <= 1'b0;
      resume      <= 1'b0;
      case (st)
        S_RUN: begin
          if (ext_rst) settle_en <= 1'b1;
          else begin
            if (settle_we) settle_en <= settle_wd;
            if (stop_req) st <= S_STOP;
          end
        end
        S_STOP: begin
          if (ext_rst) begin
            settle_en <= 1'b1;
            kind      <= K_RST;
            cnt       <= '0;
            st        <= S_SETTLE;
          end else if (wake) begin
            kind <= wk;
            if (settle_en) begin
              cnt <= '0;
              st  <= S_SETTLE;
            end else begin
              st      <= S_RUN;
              svc_nmi <= (wk == K_NMI);
              svc_irq <= (wk == K_IRQ);
              resume  <= (wk == K_RES);
            end
          end
        end
        S_SETTLE: begin
          if (ext_rst) begin
            settle_en <= 1'b1;
            kind      <= K_RST;
            cnt       <= '0;
          end else if (cnt == LAST) begin
            st          <= S_RUN;
            settle_done <= 1'b1;
            svc_nmi     <= (kind == K_NMI);
            svc_irq     <= (kind == K_IRQ);
            resume      <= (kind == K_RES);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  a_r1_stop_entry: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_RUN && stop_req && !ext_rst) |=> (stopped && !clk_en));

  a_r2_masked_ignored: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_STOP && !ext_rst && !nmi_req && irq_mask) |=> stopped);

  a_r3_nmi_wakes: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_STOP && nmi_req) |=> !stopped);

  a_r4_nmi_service: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_STOP && !ext_rst && nmi_req && !nmi_mask && !settle_en) |=> svc_nmi);

  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({svc_nmi, svc_irq, resume}));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_SETTLE) |-> (int'(cnt) < SETTLE_CYCLES));

  a_r8_reset_from_stop: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_STOP && ext_rst) |=> (core_rst && settle_en && !clk_en));

  a_r10_warm_no_settle: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_RUN && ext_rst) |=> clk_en);

endmodule

// File: tb/stop_wake_ctrl_test.sv
module stop_wake_ctrl_test;
  localparam int D = 5;

  logic clk = 0;
  logic por_n = 0, ext_rst = 0, stop_req = 0;
  logic irq_req = 0, irq_mask = 0, nmi_req = 0, nmi_mask = 0;
  logic settle_we = 0, settle_wd = 0;
  logic clk_en, stopped, core_rst, settle_en, settle_done, svc_irq, svc_nmi, resume;

  int checks = 0, fails = 0;

  stop_wake_ctrl #(.SETTLE_CYCLES(D)) uut (
    .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .stop_req(stop_req),
    .irq_req(irq_req), .irq_mask(irq_mask), .nmi_req(nmi_req), .nmi_mask(nmi_mask),
    .settle_we(settle_we), .settle_wd(settle_wd), .clk_en(clk_en), .stopped(stopped),
    .core_rst(core_rst), .settle_en(settle_en), .settle_done(settle_done),
    .svc_irq(svc_irq), .svc_nmi(svc_nmi), .resume(resume));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_run(output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (clk_en) break;
    end
  endtask

  task automatic set_settle(input bit v);
    settle_we = 1; settle_wd = v;
    @(negedge clk);
    settle_we = 0;
  endtask

  task automatic enter_stop();
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    chk(stopped && !clk_en, "R1", {stopped, clk_en}, 2);
  endtask

  initial begin
    int n;
    #400000;
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    chk(!clk_en && core_rst && settle_en, "R9 reset state", {clk_en, core_rst, settle_en}, 3);
    por_n = 1;
    wait_run(n);
    chk(n == D, "R9 por settle", n, D);
    chk(!core_rst, "R9 core_rst released", core_rst, 0);

    irq_req = 1; nmi_req = 1;
    repeat (3) begin
      @(negedge clk);
      chk(!svc_irq && !svc_nmi && !resume && clk_en, "R12", {svc_irq, svc_nmi, resume}, 0);
    end
    irq_req = 0; nmi_req = 0;

    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 16; m++) begin
        bit nr, nm, ir, im, wk;
        int exp_n;
        nr = m[3]; nm = m[2]; ir = m[1]; im = m[0];
        set_settle(s[0]);
        chk(settle_en == s[0], "R7 write", settle_en, s);
        enter_stop();
        nmi_req = nr; nmi_mask = nm; irq_req = ir; irq_mask = im;
        wk = nr | (ir & ~im);
        if (!wk) begin
          repeat (3 * D) @(negedge clk);
          chk(stopped && !clk_en, "R2 masked ignored", stopped, 1);
          nmi_req = 0; irq_req = 0; nmi_mask = 1; nmi_req = 1;
          wait_run(n);
          chk(resume && !svc_nmi && !svc_irq, "R5 exit", resume, 1);
        end else begin
          exp_n = s ? D + 1 : 1;
          wait_run(n);
          chk(n == exp_n, s ? "R6 settle length" : "R6 no settle", n, exp_n);
          chk(settle_done == s[0], "R6 done pulse", settle_done, s);
          if (nr) begin
            chk(svc_nmi == !nm, nm ? "R5 no service" : "R4 nmi service", svc_nmi, !nm);
            chk(resume == nm, "R3 nmi outcome", resume, nm);
            chk(!svc_irq, "R11 nmi over irq", svc_irq, 0);
          end else begin
            chk(svc_irq && !svc_nmi && !resume, "R2 irq service", svc_irq, 1);
          end
        end
        nmi_req = 0; irq_req = 0; nmi_mask = 0; irq_mask = 0;
        @(negedge clk);
        chk(!svc_irq && !svc_nmi && !resume, "R4 single pulse", {svc_irq, svc_nmi, resume}, 0);
      end
    end

    set_settle(0);
    ext_rst = 1;
    @(negedge clk);
    chk(clk_en && core_rst, "R10 warm reset running", {clk_en, core_rst}, 3);
    ext_rst = 0;
    @(negedge clk);
    chk(clk_en && !core_rst && settle_en, "R7 reset sets bit", settle_en, 1);

    set_settle(0);
    enter_stop();
    ext_rst = 1; nmi_req = 1; irq_req = 1;
    @(negedge clk);
    ext_rst = 0; nmi_req = 0; irq_req = 0;
    chk(core_rst && settle_en && !clk_en, "R8 reset from stop", {core_rst, settle_en}, 3);
    n = 1;
    for (int i = 0; i < 100; i++) begin
      if (clk_en) break;
      chk(core_rst, "R8 core_rst held", core_rst, 1);
      @(negedge clk);
      n++;
    end
    chk(n == D + 1, "R8 settle forced", n, D + 1);
    chk(!svc_irq && !svc_nmi && !resume, "R11 reset priority", {svc_irq, svc_nmi, resume}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule